// File: doc/BRIEF.md
# Boost Startup Fault Sequencer

This block is the digital control sequencer of a synchronous boost regulator. It takes the regulator from shutdown to steady regulation in a fixed order. First come two linear pre-charge phases that charge the output from a current source, the second with a stronger setting. Next comes a soft-start phase, where switching begins with a reduced peak current limit that is raised step by step. The last phase is normal boost regulation. Two further states stop the regulator: a fault state with a fixed hold-off before it restarts on its own, and a thermal stop.

The analog side is outside this block. It supplies comparator flags: enable, input above the undervoltage threshold, output within 1 V of the input, output at 90 % of setpoint, output at regulation, peak current limit reached, and over-temperature. All timeouts count pulses of a slow fault-clock tick enable (`tick`), never clock cycles. The block drives the current-source select, a current-limit scale code, the switch and rectifier enables, a load-disconnect control and a state code.

The states are shutdown (SHDN), linear phase 1 (LIN1), linear phase 2 (LIN2), soft-start (SOFT), boost regulation (BOOST), fault hold-off (FAULT) and thermal stop (THERM). The transitions are:
- SHDN to LIN1 on enable with the input above UVLO.
- LIN1 to SOFT when the output comes near the input, or LIN1 to LIN2 on a timeout.
- LIN2 to SOFT when the output comes near the input, or LIN2 to FAULT on a timeout.
- SOFT to BOOST at 90 % of setpoint, or SOFT to FAULT on a timeout.
- BOOST to FAULT on sustained current limit or on output collapse.
- FAULT to LIN1 after the hold-off.
- Any enabled state to THERM on over-temperature, and THERM to SOFT once that flag clears.
- Any state to SHDN when enable drops.

Top module: `boost_seq_top`

## Requirements
- R1: A low `en` puts the machine in SHDN at the next clock, from any state. SHDN and the reset state both show `sw_en`=0, `rect_en`=0, `lin_sel`=0, `ilim_code`=0 and `disc`=1.
- R2: In SHDN, `en`=1 with `vin_ok`=1 enters LIN1 at the next clock. LIN1 drives `lin_sel`=1 (low current setting) with `disc`=0 and switching off.
- R3: In LIN1, `near_in`=1 moves to SOFT at the next clock. Otherwise the 16th tick after entry moves to LIN2.
- R4: LIN2 drives `lin_sel`=2 (high current setting). In LIN2, `near_in`=1 moves to SOFT. Otherwise the 64th tick after entry moves to FAULT.
- R5: SOFT drives `sw_en`=1 and `rect_en`=1. With n ticks since entry, `ilim_code` is 8 + floor(n/4) for n below 32 and 15 from then on.
- R6: In SOFT, `pg90`=1 moves to BOOST. Otherwise the 128th tick after entry (32 ramp ticks plus 96 at full scale) moves to FAULT.
- R7: BOOST drives `ilim_code`=15 and `sw_en`=NOT `at_reg`. The 32nd consecutive tick with `ilim_hit`=1 moves to FAULT. A tick with `ilim_hit`=0 restarts that count.
- R8: In BOOST, `near_in`=0 forces `rect_en`=0 in the same cycle and moves to FAULT at the next clock.
- R9: FAULT drives `sw_en`=0, `rect_en`=0, `lin_sel`=0 and `disc`=1. The 480th tick after entry moves to LIN1.
- R10: `ot`=1 in any enabled state other than SHDN enters THERM at the next clock. THERM holds every output off with `disc`=1, and it moves to SOFT once `ot`=0.
- R11: `state_code` encodes SHDN=0, LIN1=1, LIN2=2, SOFT=3, BOOST=4, FAULT=5, THERM=6. Every tick count restarts on state entry, so LIN1 re-entered from FAULT gets its full 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Regulator enable |
| tick | input | 1 | One-cycle fault-clock tick enable |
| vin_ok | input | 1 | Input above undervoltage threshold |
| near_in | input | 1 | Output within 1 V of input |
| pg90 | input | 1 | Output at 90 % of setpoint |
| at_reg | input | 1 | Output at regulation point |
| ilim_hit | input | 1 | Peak current limit reached |
| ot | input | 1 | Over-temperature flag (hysteresis applied outside) |
| lin_sel | output | 2 | Linear current source: 0 off, 1 low, 2 high |
| ilim_code | output | CODE_W | Peak current-limit scale code |
| sw_en | output | 1 | Boost switch enable |
| rect_en | output | 1 | Synchronous rectifier enable |
| disc | output | 1 | Load disconnect (1 = input-output path open) |
| state_code | output | 3 | Current state code |

## Verification
In BOOST, an output collapse and a pending current-limit fault can arrive in the same cycle, and both must give one clean entry into FAULT. The collapse also has to drop the rectifier combinationally in that very cycle, before the state register reacts. The bench drops `near_in` while in BOOST and samples `rect_en` between edges, expecting it low while `state_code` still reads 4, then expects FAULT one clock later. In a separate run, it holds `ilim_hit` across a no-hit tick to show that the count restarts rather than carrying across.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

    typedef enum logic [2:0] {
        ST_SHDN  = 3'd0,
        ST_LIN1  = 3'd1,
        ST_LIN2  = 3'd2,
        ST_SOFT  = 3'd3,
        ST_BOOST = 3'd4,
        ST_FAULT = 3'd5,
        ST_THERM = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        LIN_OFF  = 2'd0,
        LIN_LOW  = 2'd1,
        LIN_HIGH = 2'd2
    } lin_sel_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boost_seq_tickcnt.sv
// Counts qualified fault-clock ticks since the last clear. A tick without
// the qualifier restarts the count; the count saturates at all ones.
module boost_seq_tickcnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         qual,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            if (!qual) begin
                cnt <= '0;
            end else if (cnt != {W{1'b1}}) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/boost_seq_ramp.sv
// Maps the ticks elapsed in soft-start to a current-limit scale code:
// half scale at entry, one step per STEP ticks, full scale after the ramp.
module boost_seq_ramp #(
    parameter int CODE_W     = 4,
    parameter int TMR_W      = 9,
    parameter int RAMP_TICKS = 32
) (
    input  logic [TMR_W-1:0]  cnt,
    output logic [CODE_W-1:0] code
);

    localparam int LEVELS = 2 ** (CODE_W - 1);
    localparam int STEP   = (RAMP_TICKS / LEVELS > 0) ? (RAMP_TICKS / LEVELS) : 1;

    always_comb begin
        if (cnt < TMR_W'(RAMP_TICKS)) begin
            code = CODE_W'(LEVELS) + CODE_W'(cnt / TMR_W'(STEP));
        end else begin
            code = {CODE_W{1'b1}};
        end
    end

endmodule

// File: rtl/boost_seq_fsm.sv
module boost_seq_fsm
    import boost_seq_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int TMR_W      = 9,
    parameter int ILIM_W     = 6,
    parameter int LIN1_TICKS = 16,
    parameter int LIN2_TICKS = 64,
    parameter int SS_LIMIT   = 128,
    parameter int ILIM_TICKS = 32,
    parameter int HOLD_TICKS = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              vin_ok,
    input  logic              near_in,
    input  logic              pg90,
    input  logic              at_reg,
    input  logic              ilim_hit,
    input  logic              ot,
    input  logic [TMR_W-1:0]  tmr_cnt,
    input  logic [ILIM_W-1:0] ilim_cnt,
    input  logic [CODE_W-1:0] ramp_code,
    output logic              entering,
    output seq_state_e        state,
    output logic [1:0]        lin_sel,
    output logic [CODE_W-1:0] ilim_code,
    output logic              sw_en,
    output logic              rect_en,
    output logic              disc
);

    seq_state_e st_q, st_d;

    logic lin1_done, lin2_done, ss_done, ilim_done, hold_done;

    assign lin1_done = tick && (tmr_cnt == TMR_W'(LIN1_TICKS - 1));
    assign lin2_done = tick && (tmr_cnt == TMR_W'(LIN2_TICKS - 1));
    assign ss_done   = tick && (tmr_cnt == TMR_W'(SS_LIMIT - 1));
    assign hold_done = tick && (tmr_cnt == TMR_W'(HOLD_TICKS - 1));
    assign ilim_done = tick && ilim_hit && (ilim_cnt == ILIM_W'(ILIM_TICKS - 1));

    // Next-state decision: enable loss first, then thermal stop, then the
    // per-state exits.
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = ST_SHDN;
        end else if (ot && (st_q != ST_SHDN)) begin
            st_d = ST_THERM;
        end else begin
            unique case (st_q)
                ST_SHDN: begin
                    if (vin_ok) st_d = ST_LIN1;
                end
                ST_LIN1: begin
                    if (near_in)        st_d = ST_SOFT;
                    else if (lin1_done) st_d = ST_LIN2;
                end
                ST_LIN2: begin
                    if (near_in)        st_d = ST_SOFT;
                    else if (lin2_done) st_d = ST_FAULT;
                end
                ST_SOFT: begin
                    if (pg90)         st_d = ST_BOOST;
                    else if (ss_done) st_d = ST_FAULT;
                end
                ST_BOOST: begin
                    if (!near_in || ilim_done) st_d = ST_FAULT;
                end
                ST_FAULT: begin
                    if (hold_done) st_d = ST_LIN1;
                end
                ST_THERM: begin
                    st_d = ST_SOFT;
                end
                default: st_d = ST_SHDN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SHDN;
        end else begin
            st_q <= st_d;
        end
    end

    assign entering = (st_d != st_q);
    assign state    = st_q;

    // Outputs per state
    always_comb begin
        lin_sel   = LIN_OFF;
        ilim_code = '0;
        sw_en     = 1'b0;
        rect_en   = 1'b0;
        disc      = 1'b1;
        unique case (st_q)
            ST_SHDN: begin
                disc = 1'b1;
            end
            ST_LIN1: begin
                lin_sel = LIN_LOW;
                disc    = 1'b0;
            end
            ST_LIN2: begin
                lin_sel = LIN_HIGH;
                disc    = 1'b0;
            end
            ST_SOFT: begin
                ilim_code = ramp_code;
                sw_en     = 1'b1;
                rect_en   = 1'b1;
                disc      = 1'b0;
            end
            ST_BOOST: begin
                ilim_code = {CODE_W{1'b1}};
                sw_en     = !at_reg;
                rect_en   = near_in;
                disc      = 1'b0;
            end
            ST_FAULT: begin
                disc = 1'b1;
            end
            ST_THERM: begin
                disc = 1'b1;
            end
            default: begin
                disc = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/boost_seq_top.sv
module boost_seq_top
    import boost_seq_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int LIN1_TICKS = 16,
    parameter int LIN2_TICKS = 64,
    parameter int RAMP_TICKS = 32,
    parameter int PG_TICKS   = 96,
    parameter int ILIM_TICKS = 32,
    parameter int HOLD_TICKS = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              vin_ok,
    input  logic              near_in,
    input  logic              pg90,
    input  logic              at_reg,
    input  logic              ilim_hit,
    input  logic              ot,
    output logic [1:0]        lin_sel,
    output logic [CODE_W-1:0] ilim_code,
    output logic              sw_en,
    output logic              rect_en,
    output logic              disc,
    output logic [2:0]        state_code
);

    localparam int SS_LIMIT = RAMP_TICKS + PG_TICKS;
    localparam int TMR_MAX  = max2(max2(LIN1_TICKS, LIN2_TICKS), max2(SS_LIMIT, HOLD_TICKS));
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int ILIM_W   = $clog2(ILIM_TICKS + 1);

    logic              entering;
    logic [TMR_W-1:0]  tmr_cnt;
    logic [ILIM_W-1:0] ilim_cnt;
    logic [CODE_W-1:0] ramp_code;
    seq_state_e        state;

    boost_seq_tickcnt #(.W(TMR_W)) state_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (entering),
        .tick  (tick),
        .qual  (1'b1),
        .cnt   (tmr_cnt)
    );

    boost_seq_tickcnt #(.W(ILIM_W)) ilim_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (entering),
        .tick  (tick),
        .qual  (ilim_hit),
        .cnt   (ilim_cnt)
    );

    boost_seq_ramp #(
        .CODE_W     (CODE_W),
        .TMR_W      (TMR_W),
        .RAMP_TICKS (RAMP_TICKS)
    ) ramp_i (
        .cnt  (tmr_cnt),
        .code (ramp_code)
    );

    boost_seq_fsm #(
        .CODE_W     (CODE_W),
        .TMR_W      (TMR_W),
        .ILIM_W     (ILIM_W),
        .LIN1_TICKS (LIN1_TICKS),
        .LIN2_TICKS (LIN2_TICKS),
        .SS_LIMIT   (SS_LIMIT),
        .ILIM_TICKS (ILIM_TICKS),
        .HOLD_TICKS (HOLD_TICKS)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .vin_ok    (vin_ok),
        .near_in   (near_in),
        .pg90      (pg90),
        .at_reg    (at_reg),
        .ilim_hit  (ilim_hit),
        .ot        (ot),
        .tmr_cnt   (tmr_cnt),
        .ilim_cnt  (ilim_cnt),
        .ramp_code (ramp_code),
        .entering  (entering),
        .state     (state),
        .lin_sel   (lin_sel),
        .ilim_code (ilim_code),
        .sw_en     (sw_en),
        .rect_en   (rect_en),
        .disc      (disc)
    );

    assign state_code = state;

endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              near_in,
    input logic              at_reg,
    input logic              ot,
    input logic [1:0]        lin_sel,
    input logic [CODE_W-1:0] ilim_code,
    input logic              sw_en,
    input logic              rect_en,
    input logic              disc,
    input logic [2:0]        state_code
);

    // R1
    shdn_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_code == 3'd0));

    // R1
    shdn_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0) |-> (disc && !sw_en && !rect_en && (lin_sel == 2'd0)));

    // R2
    lin1_low_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1) |-> (lin_sel == 2'd1) && !sw_en && !disc);

    // R4
    lin2_high_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2) |-> (lin_sel == 2'd2) && !sw_en && !disc);

    // R5
    soft_switching_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |-> (sw_en && rect_en && ilim_code[CODE_W-1]));

    // R7
    boost_switch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4) |-> ((sw_en == !at_reg) && (ilim_code == {CODE_W{1'b1}})));

    // R8
    collapse_rect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd4) && !near_in) |-> !rect_en);

    // R8
    collapse_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd4) && !near_in && en && !ot) |=> (state_code == 3'd5));

    // R9
    fault_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5) |-> (disc && !sw_en && !rect_en && (lin_sel == 2'd0)));

    // R10
    therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd6) && ot && en) |=> (state_code == 3'd6));

    // R10
    therm_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6) |-> (disc && !sw_en && !rect_en && (ilim_code == '0)));

    // R11
    state_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 3'd7);

endmodule

bind boost_seq_top boost_seq_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .near_in    (near_in),
    .at_reg     (at_reg),
    .ot         (ot),
    .lin_sel    (lin_sel),
    .ilim_code  (ilim_code),
    .sw_en      (sw_en),
    .rect_en    (rect_en),
    .disc       (disc),
    .state_code (state_code)
);

// File: tb/boost_seq_top_tb_top.sv
module boost_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 4;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic       en;
        logic       vin;
        logic       near;
        logic       pg;
        logic       reg_ok;
        logic       ilim;
        logic       ot;
        logic [7:0] ticks;
        logic [2:0] exp_state;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd0}, // R1 idle
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd1}, // R2 start
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd15, 3'd1}, // R3 not yet
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2}, // R3 16th tick
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd3}, // R4 near input
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  3'd4}, // R6 good
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  3'd4}, // R7 at reg
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0,  3'd6}, // R10 hot
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd3}, // R10 cooled
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  3'd4}, // R6 again
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  3'd0}  // R1 disable
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              tick = 1'b0;
    logic              vin_ok = 1'b0;
    logic              near_in = 1'b0;
    logic              pg90 = 1'b0;
    logic              at_reg = 1'b0;
    logic              ilim_hit = 1'b0;
    logic              ot = 1'b0;
    logic [1:0]        lin_sel;
    logic [CODE_W-1:0] ilim_code;
    logic              sw_en;
    logic              rect_en;
    logic              disc;
    logic [2:0]        state_code;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boost_seq_top #(.CODE_W(CODE_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (tick),
        .vin_ok     (vin_ok),
        .near_in    (near_in),
        .pg90       (pg90),
        .at_reg     (at_reg),
        .ilim_hit   (ilim_hit),
        .ot         (ot),
        .lin_sel    (lin_sel),
        .ilim_code  (ilim_code),
        .sw_en      (sw_en),
        .rect_en    (rect_en),
        .disc       (disc),
        .state_code (state_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        en = 1'b0; vin_ok = 1'b0; near_in = 1'b0; pg90 = 1'b0;
        at_reg = 1'b0; ilim_hit = 1'b0; ot = 1'b0; tick = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic to_boost();
        do_reset();
        en = 1'b1; vin_ok = 1'b1;
        @(negedge clk);
        near_in = 1'b1;
        @(negedge clk);
        pg90 = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        // Reset values, R1
        en = 1'b0; vin_ok = 1'b0; near_in = 1'b0; pg90 = 1'b0;
        at_reg = 1'b0; ilim_hit = 1'b0; ot = 1'b0; tick = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset state", state_code, 0);
        check("R1 reset disc", disc, 1);
        check("R1 reset sw_en", sw_en, 0);
        check("R1 reset rect_en", rect_en, 0);
        check("R1 reset lin_sel", lin_sel, 0);
        check("R1 reset ilim_code", ilim_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            en = VECS[v].en; vin_ok = VECS[v].vin; near_in = VECS[v].near;
            pg90 = VECS[v].pg; at_reg = VECS[v].reg_ok; ilim_hit = VECS[v].ilim;
            ot = VECS[v].ot;
            @(negedge clk);
            pulse_ticks(int'(VECS[v].ticks));
            check($sformatf("R11 vector %0d state", v), state_code, int'(VECS[v].exp_state));
        end

        // LIN2 timeout, fault hold-off, re-entry: R4 R9 R11 R3
        do_reset();
        en = 1'b1; vin_ok = 1'b1;
        @(negedge clk);
        check("R2 lin1 entry", state_code, 1);
        check("R2 lin1 source", lin_sel, 1);
        pulse_ticks(16);
        check("R3 lin1 timeout", state_code, 2);
        check("R4 lin2 source", lin_sel, 2);
        pulse_ticks(63);
        check("R4 lin2 before timeout", state_code, 2);
        pulse_ticks(1);
        check("R4 lin2 timeout fault", state_code, 5);
        check("R9 fault disc", disc, 1);
        check("R9 fault sw_en", sw_en, 0);
        check("R9 fault lin_sel", lin_sel, 0);
        pulse_ticks(479);
        check("R9 hold before restart", state_code, 5);
        pulse_ticks(1);
        check("R9 restart to lin1", state_code, 1);
        pulse_ticks(15);
        check("R11 lin1 count restarted", state_code, 1);
        near_in = 1'b1;
        @(negedge clk);
        check("R3 lin1 near input", state_code, 3);

        // Soft-start ramp and timeout: R5 R6
        check("R5 soft code at entry", ilim_code, 8);
        check("R5 soft sw_en", sw_en, 1);
        check("R5 soft rect_en", rect_en, 1);
        pulse_ticks(4);
        check("R5 soft code after 4", ilim_code, 9);
        pulse_ticks(24);
        check("R5 soft code after 28", ilim_code, 15);
        pulse_ticks(99);
        check("R6 soft before timeout", state_code, 3);
        check("R5 soft full scale", ilim_code, 15);
        pulse_ticks(1);
        check("R6 soft timeout fault", state_code, 5);

        // Boost: current-limit persistence and restart of count, R7
        to_boost();
        check("R7 boost entry", state_code, 4);
        check("R7 boost code", ilim_code, 15);
        check("R7 boost sw_en", sw_en, 1);
        at_reg = 1'b1;
        #1;
        check("R7 switch off at reg", sw_en, 0);
        @(negedge clk);
        at_reg = 1'b0;
        ilim_hit = 1'b1;
        pulse_ticks(31);
        check("R7 31 limit ticks", state_code, 4);
        ilim_hit = 1'b0;
        pulse_ticks(1);
        ilim_hit = 1'b1;
        pulse_ticks(31);
        check("R7 count restarted", state_code, 4);
        pulse_ticks(1);
        check("R7 sustained limit fault", state_code, 5);
        ilim_hit = 1'b0;

        // Output collapse with a pending limit count, R8
        to_boost();
        ilim_hit = 1'b1;
        pulse_ticks(31);
        near_in = 1'b0;
        #1;
        check("R8 rect off same cycle", rect_en, 0);
        check("R8 still boost", state_code, 4);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R8 collapse fault", state_code, 5);
        ilim_hit = 1'b0;

        // Thermal stop from linear phase, R10
        do_reset();
        en = 1'b1; vin_ok = 1'b1;
        @(negedge clk);
        ot = 1'b1;
        @(negedge clk);
        check("R10 therm entry", state_code, 6);
        check("R10 therm disc", disc, 1);
        check("R10 therm lin_sel", lin_sel, 0);
        pulse_ticks(3);
        check("R10 therm held", state_code, 6);
        ot = 1'b0;
        @(negedge clk);
        check("R10 therm to soft", state_code, 3);

        // Enable drop from soft-start, R1
        en = 1'b0;
        @(negedge clk);
        check("R1 disable from soft", state_code, 0);
        check("R1 disable disc", disc, 1);
        check("R1 disable sw_en", sw_en, 0);

        finish_run();
    end

endmodule